// File: doc/BRIEF.md
# Power-Up Sequencer with Strap Configuration Latch

This block walks a clock buffer from supply-off to normal operation through four numbered states and decides when its clock outputs may run. It has three stages before normal operation. It waits for the supply-valid flag. It then holds for a fixed settling delay. Finally it waits until three things are true: the input clock is detected, the power control pin is high and the PLL reports lock. Only then does it raise the output-enable flag.

The power control pin has two roles. Its first low-to-high transition after the supply becomes valid captures the strap inputs and keeps them: the frequency-select level and two tri-level address straps. Every later transition of the pin only enters or leaves power-down. The pin is asynchronous, so it passes through a synchronizer before any logic sees it. The clock-detect and lock flags are taken to be synchronous to the reference clock.

The captured frequency select is given out as a status bit. The two address straps are given out as a single decoded index from 0 to 8. A loss of supply returns the block to state 0 and marks the configuration invalid.

Top module: `pwrup_sequencer`

## Requirements
- R1: After reset the state output is 0, `out_enable` is 0 and `cfg_valid` is 0.
- R2: When `supply_ok` is sampled low at a clock edge, the state is 0 after that edge, from any state, and `cfg_valid` is 0.
- R3: In state 0 with `supply_ok` high, the next state is 1. State 1 lasts exactly DELAY_TICKS cycles and is then followed by state 2. The default DELAY_TICKS of 20000 is 0.2 ms at a 100 MHz reference.
- R4: `pwr_pin` reaches the state logic through SYNC_STAGES flip-flops. State 2 moves to state 3 at an edge where the synchronized pin, `clk_detect` and `pll_locked` are all high.
- R5: `out_enable` is high exactly when the state is 3. With `clk_detect` held low, the outputs are never enabled.
- R6: In state 3, a low synchronized pin, a low `clk_detect` or a low `pll_locked` at an edge returns the state to 2.
- R7: The first rise of the synchronized pin while the supply is valid captures the straps and sets `cfg_valid`.
- R8: Later rises of the pin do not resample the straps. The captured values are held until the supply is lost.
- R9: `cfg_freq_100` holds the captured frequency-select level: 1 selects 100 MHz and 0 selects 133.33 MHz.
- R10: Each address strap is a 2-bit level code: 00 is low, 01 is mid, 10 is high, and 11 is treated as mid. `cfg_addr_idx` is 3×level(`addr_strap1`) + level(`addr_strap0`).
- R11: If the pin, the clock detect and the lock are already present, `out_enable` rises DELAY_TICKS+2 edges after `supply_ok` is first sampled high. At the default setting this is well under the 1.8 ms power-on budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above its valid threshold |
| pwr_pin | input | 1 | Asynchronous power-good / active-low power-down pin |
| clk_detect | input | 1 | Input clock present |
| pll_locked | input | 1 | PLL reports lock |
| freq_strap | input | 1 | Frequency-select strap, 1 = 100 MHz |
| addr_strap0 | input | 2 | Tri-level address strap 0, level code |
| addr_strap1 | input | 2 | Tri-level address strap 1, level code |
| state | output | 2 | Sequencer state 0..3 |
| out_enable | output | 1 | Clock outputs allowed to run |
| cfg_valid | output | 1 | Straps have been captured |
| cfg_freq_100 | output | 1 | Captured frequency select |
| cfg_addr_idx | output | 4 | Decoded address index 0..8 |

## Verification
Some rules are checked by assertions on every cycle. A supply drop forces state 0. Every rise of the output enable follows a cycle in which the clock detect and the lock were both present. A lost lock during normal operation drops back to waiting. The delay counter never passes its limit. The captured configuration never moves while it stays valid.

Other behaviour can only be shown by the bench's scenarios. These are the exact settling length and the power-on latency. They also include the rule that later pin rises do not resample straps that have changed in the meantime. Last comes the decoding of the tri-level codes, including the 11 code, into the address index.

// File: rtl/pwrup_seq_pkg.sv
// Package: shared state encoding and tri-level strap decoding for the
// power-up sequencer. Assumes the strap level codes 00/01/10 = low/mid/high.
package pwrup_seq_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_DELAY = 2'd1,
        PS_WAIT  = 2'd2,
        PS_RUN   = 2'd3
    } pwr_state_e;

    localparam logic [1:0] LVL_LOW  = 2'd0;
    localparam logic [1:0] LVL_MID  = 2'd1;
    localparam logic [1:0] LVL_HIGH = 2'd2;

    // Map a raw tri-level code to a level; the unused code reads as mid.
    function automatic logic [1:0] tri_level(input logic [1:0] raw);
        return (raw == 2'd3) ? LVL_MID : raw;
    endfunction

endpackage

// File: rtl/pwrup_seq_sync.sv
// Module: multi-stage synchronizer for the asynchronous power pin.
// Assumes STAGES >= 2; the output lags the input by STAGES edges.
module pwrup_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin through the flip-flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pwrup_seq_timer.sv
// Module: settling-delay counter. Counts while enabled, clears otherwise,
// and flags the last cycle of a TICKS-long window. Assumes TICKS >= 2.
module pwrup_seq_timer #(
    parameter int TICKS = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int CW = $clog2(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Advance the window count while the delay state is active.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done = en && (cnt_q == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R3
endmodule

// File: rtl/pwrup_seq_strap.sv
// Module: one-shot strap capture. Samples the frequency and address straps
// on the first rise of the synchronized power pin after the supply is valid,
// then holds them until the supply is lost.
module pwrup_seq_strap
    import pwrup_seq_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             pin_sync,
    input  logic             freq_strap,
    input  logic [1:0]       addr_strap0,
    input  logic [1:0]       addr_strap1,
    output logic             cfg_valid,
    output logic             cfg_freq_100,
    output logic [IDX_W-1:0] cfg_addr_idx
);
    logic             prev_q;
    logic             valid_q;
    logic             freq_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_now;
    logic             first_rise;

    // Decode the two tri-level straps into one address index.
    always_comb begin
        idx_now = IDX_W'(tri_level(addr_strap1)) * IDX_W'(3)
                + IDX_W'(tri_level(addr_strap0));
    end

    assign first_rise = pin_sync && !prev_q && !valid_q;

    // Track the pin and capture the straps only on its first rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            valid_q <= 1'b0;
            freq_q  <= 1'b0;
            idx_q   <= '0;
        end else if (!supply_ok) begin
            prev_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            prev_q <= pin_sync;
            if (first_rise) begin
                valid_q <= 1'b1;
                freq_q  <= freq_strap;
                idx_q   <= idx_now;
            end
        end
    end

    assign cfg_valid    = valid_q;
    assign cfg_freq_100 = freq_q;
    assign cfg_addr_idx = idx_q;

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && $past(valid_q)) |-> $stable({freq_q, idx_q})); // R8
endmodule

// File: rtl/pwrup_sequencer.sv
// Module: four-state power-up sequencer (off, settle, wait, run).
// Assumes clk_detect and pll_locked are synchronous to clk; pwr_pin is
// asynchronous and is synchronized here. Outputs run only in the run state.
module pwrup_sequencer
    import pwrup_seq_pkg::*;
#(
    parameter int DELAY_TICKS = 20000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       pwr_pin,
    input  logic       clk_detect,
    input  logic       pll_locked,
    input  logic       freq_strap,
    input  logic [1:0] addr_strap0,
    input  logic [1:0] addr_strap1,
    output logic [1:0] state,
    output logic       out_enable,
    output logic       cfg_valid,
    output logic       cfg_freq_100,
    output logic [3:0] cfg_addr_idx
);
    localparam int IDX_W = 4;

    pwr_state_e state_q;
    logic       pin_sync;
    logic       delay_done;
    logic       run_ok;

    pwrup_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pwr_pin),
        .dout (pin_sync)
    );

    pwrup_seq_timer #(.TICKS(DELAY_TICKS)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state_q == PS_DELAY),
        .done (delay_done)
    );

    pwrup_seq_strap #(.IDX_W(IDX_W)) u_strap (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .pin_sync    (pin_sync),
        .freq_strap  (freq_strap),
        .addr_strap0 (addr_strap0),
        .addr_strap1 (addr_strap1),
        .cfg_valid   (cfg_valid),
        .cfg_freq_100(cfg_freq_100),
        .cfg_addr_idx(cfg_addr_idx)
    );

    assign run_ok = pin_sync && clk_detect && pll_locked;

    // Sequence the states; loss of supply wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            state_q <= PS_OFF;
        end else begin
            unique case (state_q)
                PS_OFF:   state_q <= PS_DELAY;
                PS_DELAY: if (delay_done) state_q <= PS_WAIT;
                PS_WAIT:  if (run_ok)     state_q <= PS_RUN;
                PS_RUN:   if (!run_ok)    state_q <= PS_WAIT;
                default:  state_q <= PS_OFF;
            endcase
        end
    end

    assign state      = state_q;
    assign out_enable = (state_q == PS_RUN);

    AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state == 2'd0 && !cfg_valid)); // R2

    AST_DELAY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DELAY && delay_done && supply_ok) |=> state == 2'd2); // R3

    AST_EN_NEEDS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_enable) |-> $past(clk_detect && pll_locked && supply_ok)); // R5

    AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && supply_ok && !pll_locked) |=> state == 2'd2); // R6
endmodule

// File: tb/pwrup_sequencer_test.sv
// Bench: directed corner cases then seeded random stimulus, each cycle
// compared with a cycle model built from the requirements.
module pwrup_sequencer_test;
    localparam int T    = 20;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, pwr_pin = 1'b0, clk_detect = 1'b0, pll_locked = 1'b0;
    logic freq_strap = 1'b0;
    logic [1:0] addr_strap0 = 2'd0, addr_strap1 = 2'd0;
    logic [1:0] state;
    logic out_enable, cfg_valid, cfg_freq_100;
    logic [3:0] cfg_addr_idx;

    int vectors = 0;
    int misses  = 0;
    bit finished = 1'b0;

    // model state
    int m_state = 0, m_cnt = 0, m_idx = 0;
    logic [SYNC-1:0] m_sync = '0;
    bit m_prev = 0, m_valid = 0, m_freq = 0;

    always #5 clk = ~clk;

    pwrup_sequencer #(.DELAY_TICKS(T), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwr_pin(pwr_pin),
        .clk_detect(clk_detect), .pll_locked(pll_locked),
        .freq_strap(freq_strap), .addr_strap0(addr_strap0),
        .addr_strap1(addr_strap1), .state(state), .out_enable(out_enable),
        .cfg_valid(cfg_valid), .cfg_freq_100(cfg_freq_100),
        .cfg_addr_idx(cfg_addr_idx)
    );

    function automatic int lvl(input logic [1:0] c);
        return (c == 2'd3) ? 1 : int'(c);
    endfunction

    function automatic int addr_index(input logic [1:0] a1, input logic [1:0] a0);
        return 3 * lvl(a1) + lvl(a0);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R3 state", int'(state), m_state);
        check("R5 out_enable", int'(out_enable), (m_state == 3) ? 1 : 0);
        check("R7 cfg_valid", int'(cfg_valid), int'(m_valid));
        check("R9 cfg_freq_100", int'(cfg_freq_100), int'(m_freq));
        check("R10 cfg_addr_idx", int'(cfg_addr_idx), m_idx);
    endtask

    // One model edge using the inputs currently driven.
    task automatic model_step();
        bit pg = m_sync[SYNC-1];
        bit done = (m_state == 1) && (m_cnt == T - 1);
        bit ok = pg && clk_detect && pll_locked;
        int n_state = m_state;
        int n_cnt = (m_state != 1) ? 0 : (done ? m_cnt : m_cnt + 1);
        if (!supply_ok) n_state = 0;
        else case (m_state)
            0: n_state = 1;
            1: if (done) n_state = 2;
            2: if (ok) n_state = 3;
            default: if (!ok) n_state = 2;
        endcase
        if (!supply_ok) begin
            m_valid = 0; m_prev = 0;
        end else begin
            if (pg && !m_prev && !m_valid) begin
                m_valid = 1; m_freq = freq_strap;
                m_idx = addr_index(addr_strap1, addr_strap0);
            end
            m_prev = pg;
        end
        m_sync = {m_sync[SYNC-2:0], pwr_pin};
        m_state = n_state;
        m_cnt = n_cnt;
    endtask

    task automatic apply(input bit s, input bit p, input bit cd, input bit lk,
                         input bit f, input logic [1:0] a0, input logic [1:0] a1);
        supply_ok = s; pwr_pin = p; clk_detect = cd; pll_locked = lk;
        freq_strap = f; addr_strap0 = a0; addr_strap1 = a1;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values before the first active edge after release
        check("R1 state", int'(state), 0);
        check("R1 out_enable", int'(out_enable), 0);
        check("R1 cfg_valid", int'(cfg_valid), 0);

        // R11 / R7 / R9 / R10: everything ready, count edges to enable
        n = 0;
        do begin
            apply(1, 1, 1, 1, 1, 2'd2, 2'd0);
            n++;
        end while (!out_enable && n < 100);
        check("R11 latency", n, T + 2);
        check("R10 index low/high", int'(cfg_addr_idx), 2);
        check("R9 freq 100", int'(cfg_freq_100), 1);

        // R8 / R6: pin low then high with different straps; no resample
        for (int i = 0; i < 6; i++) apply(1, 0, 1, 1, 0, 2'd1, 2'd2);
        check("R6 back to wait", int'(state), 2);
        for (int i = 0; i < 4; i++) apply(1, 1, 1, 1, 0, 2'd1, 2'd2);
        check("R8 index kept", int'(cfg_addr_idx), 2);
        check("R8 freq kept", int'(cfg_freq_100), 1);
        check("R4 run again", int'(out_enable), 1);

        // R5: no input clock, never enabled
        for (int i = 0; i < 30; i++) begin
            apply(1, 1, 0, 1, 0, 2'd0, 2'd0);
            check("R5 no clock", int'(out_enable), 0);
        end

        // R2: supply loss
        apply(0, 1, 1, 1, 0, 2'd0, 2'd0);
        check("R2 state off", int'(state), 0);
        check("R2 cfg cleared", int'(cfg_valid), 0);

        // R10 / R7: new power-up with mid code 11 and 133 MHz strap
        for (int i = 0; i < 3; i++) apply(1, 0, 1, 1, 0, 2'd3, 2'd1);
        for (int i = 0; i < 4; i++) apply(1, 1, 1, 1, 0, 2'd3, 2'd1);
        check("R10 index mid/mid", int'(cfg_addr_idx), 4);
        check("R9 freq 133", int'(cfg_freq_100), 0);
        check("R7 captured", int'(cfg_valid), 1);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            bit s  = (supply_ok == 1'b0) ? (($urandom % 4) == 0) : (($urandom % 300) != 0);
            bit p  = (($urandom % 16) == 0) ? ~pwr_pin : pwr_pin;
            bit cd = ($urandom % 40) != 0;
            bit lk = ($urandom % 40) != 0;
            apply(s, p, cd, lk, 1'($urandom), 2'($urandom), 2'($urandom));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule